// File: doc/BRIEF.md
# AC97 Transmit Frame Tag Generator

This block prepares the content of each outgoing AC97 frame. At every frame boundary it makes one decision: the frame carries data slots, a codec command, both, or nothing at all. It then builds the matching slot 0 tag and loads the payload words for slots 3 to 12 from a transmit FIFO, in ascending slot order. Bit-level serialization is left to a downstream shifter, which reads the tag and the payload registers once `frame_done_o` pulses.

Data slots are sent all-or-nothing. A frame carries data only if three things hold: the codec reported ready, the FIFO holds at least as many words as the mask selects, and none of the selected slots had its request bit raised in the previous input frame. If only some of the slots were sent, the FIFO word order would no longer match the slot order, so a raised request on any selected slot produces a frame that is fully empty. A command written through the command port stays pending until the first frame that can carry it. It travels in slots 1 and 2, and it can share a frame with data slots.

Top module: `ac97_tx_tagger`

## Requirements
- R1: `tag_o` bit 15 is the frame-valid flag and is 1 whenever any slot is sent. Bits 14 and 13 flag slots 1 and 2. Bit 12-k flags data slot 3+k, which is selected by `tx_mask_i[k]`. Bits 2:0 are always 0.
- R2: When data is sent, each selected slot 3+k receives the next FIFO word in ascending k order. Each word appears in `data_slots_o[k*20 +: 20]`.
- R3: When `codec_ready_i` is 0 at the frame start, the frame carries neither data nor command, and `tag_o` is 0.
- R4: When `fifo_level_i` is lower than the number of set bits in `tx_mask_i`, or the mask is zero, no data slot is sent and nothing is popped.
- R5: When `slot_req_i[k]` is 1 for any k with `tx_mask_i[k]`=1, the frame is fully empty: `tag_o`=0, no command is sent and no pop happens. Request bits of unselected slots have no effect.
- R6: A pulse on `cmd_wr_i` sets `cmd_pending_o` one cycle later. `cmd_pending_o` stays set until a frame carries the command, and it clears at that frame's start.
- R7: A frame that carries the command sets tag bits 15, 14 and 13. `cmd_slot1_o` carries the read flag in bit 19 and the index in bits 18:12, with zeros in bits 11:0. `cmd_slot2_o` carries the write data in bits 19:4, with zeros in bits 3:0. In a frame without a command, both slots are 0.
- R8: A pending command and data slots can be sent in the same frame.
- R9: A command written in the same cycle as `frame_start_i` is not sent in that frame. It stays pending for the next frame.
- R10: After reset, `tag_o`, the command slots, all data slots, `frame_done_o` and `cmd_pending_o` are 0.
- R11: Data slots that are not sent hold 0. The number of pops in a frame equals the number of data-slot flags set in `tag_o`.
- R12: `frame_done_o` pulses for one cycle, 10 cycles after the clock edge that samples `frame_start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame boundary pulse |
| tx_mask_i | input | 10 | Data slot select; bit k selects slot 3+k |
| fifo_level_i | input | 5 | Transmit FIFO fill level |
| fifo_data_i | input | 20 | Transmit FIFO head word (show-ahead) |
| fifo_pop_o | output | 1 | Pop the FIFO head word |
| codec_ready_i | input | 1 | Codec-ready flag from the previous input frame |
| slot_req_i | input | 10 | Slot request bits from the previous input frame; 1 means hold off |
| cmd_wr_i | input | 1 | Command register write strobe (any word) |
| cmd_read_i | input | 1 | Command read flag |
| cmd_idx_i | input | 7 | Codec register index |
| cmd_wdata_i | input | 16 | Codec register write data |
| tag_o | output | 16 | Slot 0 tag for the current frame |
| cmd_slot1_o | output | 20 | Slot 1 payload |
| cmd_slot2_o | output | 20 | Slot 2 payload |
| data_slots_o | output | 200 | Slots 3..12 payloads, slot 3+k at bits k*20 +: 20 |
| frame_done_o | output | 1 | All payloads for the frame are loaded |
| cmd_pending_o | output | 1 | A command is waiting to be sent |

## Verification
The bench builds the block with its default parameters: ten data slots, 20-bit slots and a 5-bit level. With these values the whole 1024-entry mask space is small enough to sweep exhaustively. Each mask is run against four conditions: all gates open while every unselected request bit is raised, codec not ready, a FIFO level one short of the need, and a request on the lowest selected slot. This checks every tag pattern, every pop ordering and every gating corner. A directed phase covers the command path: sending a command alone, sending it together with data, holding it while blocked, and a write that coincides with the frame start.

// File: rtl/ac97_tag_pkg.sv
package ac97_tag_pkg;
  localparam int TAG_W      = 16;
  localparam int TAG_VALID  = 15;
  localparam int TAG_SLOT1  = 14;
  localparam int TAG_SLOT2  = 13;
  localparam int TAG_DATA_HI = 12;

  typedef struct packed {
    logic send_data;
    logic send_cmd;
  } frame_plan_t;
endpackage

// File: rtl/ac97_frame_decider.sv
module ac97_frame_decider
  import ac97_tag_pkg::*;
#(
  parameter int NSLOT = 10,
  parameter int LVL_W = 5
) (
  input  logic [NSLOT-1:0] mask_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             codec_ready_i,
  input  logic [NSLOT-1:0] slot_req_i,
  input  logic             cmd_pending_i,
  output frame_plan_t      plan_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int NEED_W = LVL_W + 1;

  logic [NEED_W-1:0] need;
  logic              blocked;
  logic              enough;

  always_comb begin
    need = '0;
    for (int k = 0; k < NSLOT; k++) need = need + NEED_W'(mask_i[k]);
  end

  assign blocked = |(slot_req_i & mask_i);
  assign enough  = {1'b0, level_i} >= need;

  assign plan_o.send_data = codec_ready_i & (|mask_i) & enough & ~blocked;
  assign plan_o.send_cmd  = codec_ready_i & cmd_pending_i & ~blocked;

  always_comb begin
    tag_o            = '0;
    tag_o[TAG_VALID] = plan_o.send_data | plan_o.send_cmd;
    tag_o[TAG_SLOT1] = plan_o.send_cmd;
    tag_o[TAG_SLOT2] = plan_o.send_cmd;
    for (int k = 0; k < NSLOT; k++)
      tag_o[TAG_DATA_HI-k] = plan_o.send_data & mask_i[k];
  end
endmodule

// File: rtl/ac97_cmd_reg.sv
module ac97_cmd_reg #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              read_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              consume_i,
  output logic              pending_o,
  output logic [SLOT_W-1:0] slot1_word_o,
  output logic [SLOT_W-1:0] slot2_word_o
);
  localparam int S1_PAD = SLOT_W - 1 - IDX_W;
  localparam int S2_PAD = SLOT_W - DATA_W;

  logic              read_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= 1'b0;
      read_q    <= 1'b0;
      idx_q     <= '0;
      data_q    <= '0;
    end else if (wr_i) begin
      // a new write always wins over a same-cycle send
      pending_o <= 1'b1;
      read_q    <= read_i;
      idx_q     <= idx_i;
      data_q    <= wdata_i;
    end else if (consume_i) begin
      pending_o <= 1'b0;
    end
  end

  assign slot1_word_o = {read_q, idx_q, {S1_PAD{1'b0}}};
  assign slot2_word_o = {data_q, {S2_PAD{1'b0}}};

  // R6
  wr_sets_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pending_o);
  // R6
  consume_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i && !wr_i |=> !pending_o);
endmodule

// File: rtl/ac97_slot_filler.sv
module ac97_slot_filler #(
  parameter int NSLOT  = 10,
  parameter int SLOT_W = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    send_data_i,
  input  logic [NSLOT-1:0]        mask_i,
  input  logic [SLOT_W-1:0]       fifo_data_i,
  output logic                    fifo_pop_o,
  output logic [NSLOT*SLOT_W-1:0] slots_o,
  output logic                    done_o
);
  localparam int POS_W = $clog2(NSLOT);

  logic              busy_q, send_q;
  logic [POS_W-1:0]  pos_q;
  logic [NSLOT-1:0]  mask_q;
  logic [SLOT_W-1:0] slot_q [NSLOT];

  assign fifo_pop_o = busy_q & send_q & mask_q[pos_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      send_q <= 1'b0;
      pos_q  <= '0;
      mask_q <= '0;
      done_o <= 1'b0;
      for (int k = 0; k < NSLOT; k++) slot_q[k] <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      send_q <= send_data_i;
      pos_q  <= '0;
      mask_q <= mask_i;
      done_o <= 1'b0;
      for (int k = 0; k < NSLOT; k++) slot_q[k] <= '0;
    end else if (busy_q) begin
      if (fifo_pop_o) slot_q[pos_q] <= fifo_data_i;
      if (pos_q == POS_W'(NSLOT-1)) begin
        busy_q <= 1'b0;
        done_o <= 1'b1;
      end else begin
        pos_q  <= pos_q + 1'b1;
        done_o <= 1'b0;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_out
    assign slots_o[g*SLOT_W +: SLOT_W] = slot_q[g];
  end

  // R12
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/ac97_tx_tagger.sv
module ac97_tx_tagger
  import ac97_tag_pkg::*;
#(
  parameter int NSLOT  = 10,
  parameter int SLOT_W = 20,
  parameter int LVL_W  = 5,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_start_i,
  input  logic [NSLOT-1:0]        tx_mask_i,
  input  logic [LVL_W-1:0]        fifo_level_i,
  input  logic [SLOT_W-1:0]       fifo_data_i,
  output logic                    fifo_pop_o,
  input  logic                    codec_ready_i,
  input  logic [NSLOT-1:0]        slot_req_i,
  input  logic                    cmd_wr_i,
  input  logic                    cmd_read_i,
  input  logic [IDX_W-1:0]        cmd_idx_i,
  input  logic [DATA_W-1:0]       cmd_wdata_i,
  output logic [TAG_W-1:0]        tag_o,
  output logic [SLOT_W-1:0]       cmd_slot1_o,
  output logic [SLOT_W-1:0]       cmd_slot2_o,
  output logic [NSLOT*SLOT_W-1:0] data_slots_o,
  output logic                    frame_done_o,
  output logic                    cmd_pending_o
);
  localparam int CNT_W = $clog2(NSLOT + 1);

  frame_plan_t       plan;
  logic [TAG_W-1:0]  tag_next;
  logic [SLOT_W-1:0] s1_word, s2_word;

  ac97_frame_decider #(.NSLOT(NSLOT), .LVL_W(LVL_W)) u_decide (
    .mask_i        (tx_mask_i),
    .level_i       (fifo_level_i),
    .codec_ready_i (codec_ready_i),
    .slot_req_i    (slot_req_i),
    .cmd_pending_i (cmd_pending_o),
    .plan_o        (plan),
    .tag_o         (tag_next)
  );

  ac97_cmd_reg #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (cmd_wr_i),
    .read_i       (cmd_read_i),
    .idx_i        (cmd_idx_i),
    .wdata_i      (cmd_wdata_i),
    .consume_i    (frame_start_i & plan.send_cmd),
    .pending_o    (cmd_pending_o),
    .slot1_word_o (s1_word),
    .slot2_word_o (s2_word)
  );

  ac97_slot_filler #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (frame_start_i),
    .send_data_i (plan.send_data),
    .mask_i      (tx_mask_i),
    .fifo_data_i (fifo_data_i),
    .fifo_pop_o  (fifo_pop_o),
    .slots_o     (data_slots_o),
    .done_o      (frame_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o       <= '0;
      cmd_slot1_o <= '0;
      cmd_slot2_o <= '0;
    end else if (frame_start_i) begin
      tag_o       <= tag_next;
      cmd_slot1_o <= plan.send_cmd ? s1_word : '0;
      cmd_slot2_o <= plan.send_cmd ? s2_word : '0;
    end
  end

  // pops seen in the current frame, for the pop-count check
  logic [CNT_W-1:0] pop_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pop_seen <= '0;
    else if (frame_start_i) pop_seen <= '0;
    else if (fifo_pop_o)    pop_seen <= pop_seen + 1'b1;
  end

  // R3
  not_ready_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !codec_ready_i |=> tag_o == '0);
  // R5
  req_block_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && |(slot_req_i & tx_mask_i) |=> tag_o == '0 && cmd_slot1_o == '0);
  // R7
  cmd_slot_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> tag_o[TAG_SLOT1] == tag_o[TAG_SLOT2]);
  // R11
  pop_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> pop_seen == CNT_W'($countones(tag_o[TAG_DATA_HI -: NSLOT])));
  // R1
  valid_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> tag_o[TAG_VALID] == (|tag_o[TAG_SLOT1:0]));
endmodule

// File: tb/sim_ac97_tx_tagger.sv
module sim_ac97_tx_tagger;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         frame_start = 1'b0, codec_ready = 1'b0;
  logic [9:0]   tx_mask = '0, slot_req = '0;
  logic [4:0]   fifo_level = '0;
  logic [19:0]  fifo_data;
  logic         fifo_pop;
  logic         cmd_wr = 1'b0, cmd_read = 1'b0;
  logic [6:0]   cmd_idx = '0;
  logic [15:0]  cmd_wdata = '0;
  logic [15:0]  tag;
  logic [19:0]  slot1, slot2;
  logic [199:0] dslots;
  logic         done, pending;

  int vectors = 0, fails = 0;
  int popcnt  = 0;

  bit          m_pend = 0, m_read = 0;
  logic [6:0]  m_idx  = '0;
  logic [15:0] m_data = '0;

  function automatic logic [19:0] word(int n);
    return 20'((n * 7919 + 333) & 'hFFFFF);
  endfunction

  assign fifo_data = word(popcnt);
  always @(posedge clk) if (rst_n && fifo_pop) popcnt <= popcnt + 1;

  ac97_tx_tagger u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start),
    .tx_mask_i(tx_mask), .fifo_level_i(fifo_level), .fifo_data_i(fifo_data),
    .fifo_pop_o(fifo_pop), .codec_ready_i(codec_ready), .slot_req_i(slot_req),
    .cmd_wr_i(cmd_wr), .cmd_read_i(cmd_read), .cmd_idx_i(cmd_idx),
    .cmd_wdata_i(cmd_wdata), .tag_o(tag), .cmd_slot1_o(slot1),
    .cmd_slot2_o(slot2), .data_slots_o(dslots), .frame_done_o(done),
    .cmd_pending_o(pending)
  );

  task automatic check(bit ok, string rq, logic [255:0] act, logic [255:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cmd_write(bit rd, logic [6:0] idx, logic [15:0] dat);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_read = rd; cmd_idx = idx; cmd_wdata = dat;
    @(negedge clk);
    cmd_wr = 1'b0;
    m_pend = 1; m_read = rd; m_idx = idx; m_data = dat;
    check(pending == 1'b1, "R6 pending after write", 256'(pending), 256'(1));
  endtask

  task automatic run_frame(logic [9:0] m, bit rdy, int lvl, logic [9:0] rq,
                           bit wr_same, string rtag);
    int need, base, rank, n;
    bit sd, sc, blocked;
    logic [15:0]  etag;
    logic [199:0] eslots;
    logic [19:0]  e1, e2;
    need = $countones(m);
    blocked = (rq & m) != 0;
    sd = rdy && (m != 0) && (lvl >= need) && !blocked;
    sc = rdy && m_pend && !blocked;
    etag = '0;
    etag[15] = sd | sc; etag[14] = sc; etag[13] = sc;
    for (int k = 0; k < 10; k++) etag[12-k] = sd & m[k];
    e1 = sc ? {m_read, m_idx, 12'h000} : 20'h0;
    e2 = sc ? {m_data, 4'h0} : 20'h0;
    @(negedge clk);
    base = popcnt;
    rank = 0;
    eslots = '0;
    for (int k = 0; k < 10; k++)
      if (sd && m[k]) begin eslots[k*20 +: 20] = word(base + rank); rank++; end
    tx_mask = m; codec_ready = rdy; fifo_level = 5'(lvl); slot_req = rq;
    frame_start = 1'b1;
    if (wr_same) begin
      cmd_wr = 1'b1; cmd_read = 1'b1; cmd_idx = 7'h55; cmd_wdata = 16'hBEEF;
    end
    @(negedge clk);
    frame_start = 1'b0; cmd_wr = 1'b0;
    if (sc) m_pend = 0;
    if (wr_same) begin m_pend = 1; m_read = 1; m_idx = 7'h55; m_data = 16'hBEEF; end
    n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    check(n == 10, "R12 done latency", 256'(n), 256'(10));
    check(tag == etag, rtag, 256'(tag), 256'(etag));
    check(dslots == eslots, "R2/R11 data slots", 256'(dslots), 256'(eslots));
    check(popcnt - base == rank, "R4/R11 pop count", 256'(popcnt - base), 256'(rank));
    check(slot1 == e1 && slot2 == e2, "R7 command slots",
          256'({slot1, slot2}), 256'({e1, e2}));
    check(pending == m_pend, "R6 pending", 256'(pending), 256'(m_pend));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    check(tag == 0 && slot1 == 0 && slot2 == 0 && dslots == 0 && !done && !pending,
          "R10 reset state", 256'({tag, done, pending}), 256'(0));

    // command alone (R7, R6)
    cmd_write(1'b0, 7'h26, 16'h1234);
    run_frame(10'h000, 1'b1, 0, 10'h000, 1'b0, "R7 cmd only tag");
    // command with data (R8)
    cmd_write(1'b1, 7'h7F, 16'hA5C3);
    run_frame(10'h205, 1'b1, 3, 10'h000, 1'b0, "R8 cmd plus data tag");
    // held while codec not ready (R3), then blocked (R5), then sent
    cmd_write(1'b0, 7'h01, 16'hFFFF);
    run_frame(10'h00F, 1'b0, 20, 10'h000, 1'b0, "R3 not ready tag");
    run_frame(10'h00F, 1'b1, 20, 10'h008, 1'b0, "R5 request block tag");
    run_frame(10'h00F, 1'b1, 20, 10'h3F0, 1'b0, "R5 unselected req ignored tag");
    // write coinciding with frame start (R9)
    run_frame(10'h3FF, 1'b1, 10, 10'h000, 1'b1, "R9 same-cycle write tag");
    check(pending == 1'b1, "R9 still pending", 256'(pending), 256'(1));
    run_frame(10'h3FF, 1'b1, 10, 10'h000, 1'b0, "R9 next frame sends tag");
    // full-mask FIFO edge: exactly enough and one short (R4)
    run_frame(10'h3FF, 1'b1, 9, 10'h000, 1'b0, "R4 one short tag");

    // exhaustive mask sweep (R1 R2 R3 R4 R5)
    for (int mi = 0; mi < 1024; mi++) begin
      logic [9:0] m;
      int nd;
      m = 10'(mi);
      nd = $countones(m);
      run_frame(m, 1'b1, nd, ~m, 1'b0, "R1 sweep open tag");
      run_frame(m, 1'b0, 31, 10'h000, 1'b0, "R3 sweep not ready tag");
      run_frame(m, 1'b1, (nd > 0) ? nd - 1 : 0, 10'h000, 1'b0, "R4 sweep short tag");
      run_frame(m, 1'b1, 31, m & (~m + 10'd1), 1'b0, "R5 sweep req tag");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule